// File: doc/BRIEF.md
# Command List Sequencer with Host Handshake

This block walks a host-supplied list of commands one entry at a time. The host writes a length and raises a list-present flag. The sequencer then issues one command strobe per iteration, together with the index of that command. It waits for an external executor to report completion before it issues the next command. The commands themselves are opaque to the block, and the completion input stands in for whatever unit carries them out.

Between iterations the host can request a pause, a resume or an abort. These requests are looked at only when no command is outstanding, so a command that has started always finishes. When the list has been exhausted or aborted, the block spends one cycle capturing a reply: the number of commands that completed and whether the list ended early. It then holds an acknowledge until the host drops the list-present flag, and after that it returns to idle.

Top module: `cmd_list_ctrl`

## Requirements
- R1: After reset, state_o is 0 (idle), cmd_issue_o and ack_o are low, and reply_count_o and reply_aborted_o are zero.
- R2: In idle, a high list_flag_i captures list_len_i and moves the state to 1 (executing) on the next clock edge, with the command count cleared.
- R3: In executing, each iteration raises cmd_issue_o for exactly one cycle with cmd_idx_o equal to the number of commands already completed (0, 1, 2, ...). No further issue happens until cmd_done_i has been seen high for that command.
- R4: A cmd_done_i pulse while no command is outstanding is ignored and does not change the count reported in the reply.
- R5: At a command boundary, a high pause_req_i (with no abort pending and commands remaining) moves the state to 2 (paused), and no command is issued while paused. A high resume_req_i in paused returns the state to 1.
- R6: A high abort_req_i at a boundary with commands remaining, or in paused, moves the state to 3 (reply). The reply then shows reply_aborted_o = 1 and reply_count_o equal to the commands completed.
- R7: Pause and abort requests that arrive while a command is outstanding take effect only after that command's cmd_done_i. The outstanding command is counted.
- R8: When the completed count reaches the captured length, the state goes to 3 with reply_aborted_o = 0 and reply_count_o equal to the length. Completion takes priority over an abort raised at that final boundary.
- R9: State 3 lasts one cycle and is followed by state 4 (acknowledge), in which ack_o is high and the reply is valid. State 4 holds while list_flag_i stays high and goes to 0 on the edge after it is seen low.
- R10: A list of length 0 issues no command and replies with count 0, not aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| list_flag_i | input | 1 | Host list-present flag |
| list_len_i | input | CNT_W | Number of commands in the list |
| pause_req_i | input | 1 | Pause request, level |
| resume_req_i | input | 1 | Resume request, level |
| abort_req_i | input | 1 | Abort request, level |
| cmd_done_i | input | 1 | Executor reports the current command complete |
| cmd_issue_o | output | 1 | One-cycle strobe starting a command |
| cmd_idx_o | output | CNT_W | Index of the command being issued |
| state_o | output | 3 | Current state: 0 idle, 1 executing, 2 paused, 3 reply, 4 acknowledge |
| ack_o | output | 1 | Acknowledge, high in state 4 |
| reply_count_o | output | CNT_W | Commands completed in the last list |
| reply_aborted_o | output | 1 | Last list ended by abort |

## Verification
The hardest case to reach is a request that lands while a command is still outstanding. It has to be deferred, and the command in flight still has to be counted. The bench's executor model answers each issue only after a programmable delay. Stimulus waits until the monitor has seen a given number of issues, then raises pause or abort inside that open window. The bench checks that the state stays in executing until the completion arrives. Abort is also raised at the final boundary, to show that normal completion wins, and stray completion pulses are injected while paused.

// File: rtl/cmd_list_pkg.sv
package cmd_list_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_EXEC   = 3'd1,
    ST_PAUSED = 3'd2,
    ST_REPLY  = 3'd3,
    ST_ACK    = 3'd4
  } state_e;
endpackage

// File: rtl/cmd_list_seq.sv
// Iteration bookkeeping: captured length, completed count, outstanding flag.
module cmd_list_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             issue_i,
  input  logic             done_i,
  output logic [CNT_W-1:0] count_o,
  output logic             in_flight_o,
  output logic             at_end_o
);
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] count_q;
  logic             in_flight_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q       <= '0;
      count_q     <= '0;
      in_flight_q <= 1'b0;
    end else if (start_i) begin
      len_q       <= len_i;
      count_q     <= '0;
      in_flight_q <= 1'b0;
    end else if (issue_i) begin
      in_flight_q <= 1'b1;
    end else if (in_flight_q && done_i) begin
      // completion only counts against an outstanding command
      in_flight_q <= 1'b0;
      count_q     <= count_q + 1'b1;
    end
  end

  assign count_o     = count_q;
  assign in_flight_o = in_flight_q;
  assign at_end_o    = (count_q == len_q);

  assert_issue_arms_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> (in_flight_q && $stable(count_q)));

  assert_count_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= len_q);

  assert_stray_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_flight_q && !issue_i && !start_i) |=> $stable(count_q));
endmodule

// File: rtl/cmd_list_fsm.sv
module cmd_list_fsm
  import cmd_list_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   list_flag_i,
  input  logic   pause_req_i,
  input  logic   resume_req_i,
  input  logic   abort_req_i,
  input  logic   in_flight_i,
  input  logic   at_end_i,
  output state_e state_o,
  output logic   start_o,
  output logic   issue_o,
  output logic   prep_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    issue_o = 1'b0;
    start_o = 1'b0;
    prep_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (list_flag_i) begin
          start_o = 1'b1;
          state_d = ST_EXEC;
        end
      end
      ST_EXEC: begin
        // decisions only at a boundary: nothing outstanding
        if (!in_flight_i) begin
          if (at_end_i)          state_d = ST_REPLY;
          else if (abort_req_i)  state_d = ST_REPLY;
          else if (pause_req_i)  state_d = ST_PAUSED;
          else                   issue_o = 1'b1;
        end
      end
      ST_PAUSED: begin
        if (abort_req_i)        state_d = ST_REPLY;
        else if (resume_req_i)  state_d = ST_EXEC;
      end
      ST_REPLY: begin
        prep_o  = 1'b1;
        state_d = ST_ACK;
      end
      ST_ACK: begin
        if (!list_flag_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_defer_request_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && in_flight_i) |=> (state_q == ST_EXEC));

  assert_ack_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK && list_flag_i) |=> (state_q == ST_ACK));

  assert_ack_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK && !list_flag_i) |=> (state_q == ST_IDLE));

  assert_reply_one_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REPLY) |=> (state_q == ST_ACK));
endmodule

// File: rtl/cmd_list_reply.sv
module cmd_list_reply #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prep_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             at_end_i,
  output logic [CNT_W-1:0] reply_count_o,
  output logic             reply_aborted_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reply_count_o   <= '0;
      reply_aborted_o <= 1'b0;
    end else if (prep_i) begin
      reply_count_o   <= count_i;
      // short of the length only if the list was cut off
      reply_aborted_o <= !at_end_i;
    end
  end

  assert_reply_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prep_i |=> ($stable(reply_count_o) && $stable(reply_aborted_o)));
endmodule

// File: rtl/cmd_list_ctrl.sv
module cmd_list_ctrl
  import cmd_list_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             list_flag_i,
  input  logic [CNT_W-1:0] list_len_i,
  input  logic             pause_req_i,
  input  logic             resume_req_i,
  input  logic             abort_req_i,
  input  logic             cmd_done_i,
  output logic             cmd_issue_o,
  output logic [CNT_W-1:0] cmd_idx_o,
  output logic [2:0]       state_o,
  output logic             ack_o,
  output logic [CNT_W-1:0] reply_count_o,
  output logic             reply_aborted_o
);
  state_e           state;
  logic             start, issue, prep, in_flight, at_end;
  logic [CNT_W-1:0] count;

  cmd_list_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .list_flag_i  (list_flag_i),
    .pause_req_i  (pause_req_i),
    .resume_req_i (resume_req_i),
    .abort_req_i  (abort_req_i),
    .in_flight_i  (in_flight),
    .at_end_i     (at_end),
    .state_o      (state),
    .start_o      (start),
    .issue_o      (issue),
    .prep_o       (prep)
  );

  cmd_list_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .len_i       (list_len_i),
    .issue_i     (issue),
    .done_i      (cmd_done_i),
    .count_o     (count),
    .in_flight_o (in_flight),
    .at_end_o    (at_end)
  );

  cmd_list_reply #(.CNT_W(CNT_W)) u_reply (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .prep_i          (prep),
    .count_i         (count),
    .at_end_i        (at_end),
    .reply_count_o   (reply_count_o),
    .reply_aborted_o (reply_aborted_o)
  );

  assign cmd_issue_o = issue;
  assign cmd_idx_o   = count;
  assign state_o     = state;
  assign ack_o       = (state == ST_ACK);
endmodule

// File: tb/cmd_list_ctrl_tb.sv
`timescale 1ns/1ps
module cmd_list_ctrl_tb;
  localparam int CNT_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             list_flag_i = 1'b0;
  logic [CNT_W-1:0] list_len_i = '0;
  logic             pause_req_i = 1'b0;
  logic             resume_req_i = 1'b0;
  logic             abort_req_i = 1'b0;
  logic             exec_done = 1'b0;
  logic             stray_done = 1'b0;
  logic             cmd_done_i;
  logic             cmd_issue_o;
  logic [CNT_W-1:0] cmd_idx_o;
  logic [2:0]       state_o;
  logic             ack_o;
  logic [CNT_W-1:0] reply_count_o;
  logic             reply_aborted_o;

  assign cmd_done_i = exec_done | stray_done;

  always #10 clk_i = ~clk_i;

  cmd_list_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .list_flag_i(list_flag_i), .list_len_i(list_len_i),
    .pause_req_i(pause_req_i), .resume_req_i(resume_req_i), .abort_req_i(abort_req_i),
    .cmd_done_i(cmd_done_i), .cmd_issue_o(cmd_issue_o), .cmd_idx_o(cmd_idx_o),
    .state_o(state_o), .ack_o(ack_o), .reply_count_o(reply_count_o),
    .reply_aborted_o(reply_aborted_o)
  );

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  int issues_seen = 0;
  int pend = 0;
  int exec_delay = 1;
  bit issue_window = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver side: expected issue indices
  task automatic push_issues(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(i);
  endtask

  // monitor + executor model
  always @(negedge clk_i) begin
    exec_done <= 1'b0;
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) exec_done <= 1'b1;
    end
    if (cmd_issue_o) begin
      issues_seen++;
      checks++;
      if (!issue_window || exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3 unexpected issue actual=%0d expected=none", cmd_idx_o);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(cmd_idx_o) != e) begin
          errors++;
          $display("FAIL R3 issue index actual=%0d expected=%0d", cmd_idx_o, e);
        end
      end
      pend = exec_delay;
    end
  end

  task automatic wait_state(input int s);
    int n = 0;
    while (int'(state_o) != s && n < 2000) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic wait_issues(input int n);
    int k = 0;
    while (issues_seen < n && k < 2000) begin
      @(negedge clk_i);
      k++;
    end
  endtask

  task automatic start_list(input int len, input int n_exp, input int dly);
    exec_delay   = dly;
    issues_seen  = 0;
    issue_window = 1'b1;
    push_issues(n_exp);
    list_len_i   = CNT_W'(len);
    list_flag_i  = 1'b1;
  endtask

  task automatic finish_list(input string req, input int cnt, input int abrt);
    wait_state(4);
    chk(req, int'(reply_count_o), cnt);
    chk(req, int'(reply_aborted_o), abrt);
    chk("R9", int'(ack_o), 1);
    repeat (3) @(negedge clk_i);
    chk("R9", int'(state_o), 4);
    list_flag_i = 1'b0;
    @(negedge clk_i);
    chk("R9", int'(state_o), 0);
    chk("R3", exp_q.size(), 0);
    issue_window = 1'b0;
    pause_req_i = 1'b0;
    abort_req_i = 1'b0;
    resume_req_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", int'(state_o), 0);
    chk("R1", int'(cmd_issue_o), 0);
    chk("R1", int'(ack_o), 0);
    chk("R1", int'(reply_count_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R2/R8: plain list of three
    start_list(3, 3, 2);
    @(negedge clk_i);
    chk("R2", int'(state_o), 1);
    finish_list("R8", 3, 0);

    // R5/R7/R4: pause requested mid-command, stray completions while paused
    start_list(4, 4, 3);
    wait_issues(2);
    pause_req_i = 1'b1;
    @(negedge clk_i);
    chk("R7", int'(state_o), 1);
    @(negedge clk_i);
    chk("R7", int'(state_o), 1);
    wait_state(2);
    chk("R5", int'(state_o), 2);
    chk("R7", issues_seen, 2);
    stray_done = 1'b1;
    @(negedge clk_i);
    stray_done = 1'b0;
    repeat (4) @(negedge clk_i);
    chk("R5", issues_seen, 2);
    chk("R5", int'(state_o), 2);
    pause_req_i = 1'b0;
    resume_req_i = 1'b1;
    @(negedge clk_i);
    resume_req_i = 1'b0;
    chk("R5", int'(state_o), 1);
    finish_list("R4", 4, 0);

    // R6: abort while paused
    start_list(5, 2, 1);
    wait_issues(2);
    pause_req_i = 1'b1;
    wait_state(2);
    abort_req_i = 1'b1;
    @(negedge clk_i);
    chk("R6", int'(state_o), 3);
    finish_list("R6", 2, 1);

    // R7/R6: abort while a command is outstanding
    start_list(6, 3, 2);
    wait_issues(3);
    abort_req_i = 1'b1;
    @(negedge clk_i);
    chk("R7", int'(state_o), 1);
    finish_list("R7", 3, 1);

    // R8: abort at final boundary loses to completion
    start_list(2, 2, 2);
    wait_issues(2);
    abort_req_i = 1'b1;
    finish_list("R8", 2, 0);

    // R10: empty list
    start_list(0, 0, 1);
    finish_list("R10", 0, 0);
    chk("R10", issues_seen, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule